// File: doc/BRIEF.md
# Store Request and Busy Line Controller

This controller sits between a nonvolatile-backed SRAM and a single shared, active-low, open-drain line. The system uses that line in two directions. It pulls the line low to ask for a hardware store. The controller pulls the line low to report that a store is running, whatever started that store. The incoming level passes through a synchroniser. The controller then lets a programmable grace window elapse so that accesses already under way can finish. After the window it starts the store engine only when the array holds data that has not yet been saved.

A dirty flag records unsaved data. Any write that reaches the SRAM sets it, and the end of a store or of a recall clears it. Once the synchronised line is low, new writes are gated off. Reads stay available during the grace window. While a store runs, and afterwards until the line is seen high again, the memory accepts no accesses. A software-requested store takes the same busy path and skips the grace window. The store engine is reached through a one-cycle start pulse and a done pulse.

Top module: `nvs_store_handshake`

## Requirements
- R1: After reset the line enable is 0, the start pulse is 0, and with the line high both read and write requests pass straight to the SRAM enables.
- R2: With the default two synchroniser stages, the raw line may be first sampled low at rising edge k. If a store is needed, eng_start_o is then high in the cycle after edge k+2+DELAY_CYC.
- R3: When the grace window ends with the dirty flag clear, no start pulse is issued and the line enable stays 0.
- R4: The dirty flag is set by every write passed to the SRAM. It is cleared by eng_done_i during a store and by recall_done_i. If a passed write and recall_done_i fall in the same cycle, the flag stays set.
- R5: A write presented while the synchronised line is still high is passed. This includes the two cycles after the raw line falls. From the first cycle in which the synchronised line is low, writes are blocked until the controller is back in idle. A blocked write does not set the dirty flag.
- R6: Reads are passed during the grace window. After a request that needed no store, reads are also passed while the controller waits for the line to return high.
- R7: While a store runs, req_line_oe_o is 1 (the line is driven low) and reads and writes are blocked. eng_start_o is a single-cycle pulse in the first store cycle.
- R8: req_line_oe_o stays 1 until eng_done_i is seen and drops to 0 in the following cycle.
- R9: After a store, reads and writes stay blocked until the synchronised line is high. With two stages, access reopens after the third rising edge after the raw line returns high.
- R10: A software store pulse in idle, with the line high, starts the engine in the next cycle whether or not the flag is dirty, and the line is driven low for that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_line_i | input | 1 | Raw level of the shared request/busy line |
| req_line_oe_o | output | 1 | Open-drain enable: 1 pulls the line low |
| sw_store_i | input | 1 | Single-cycle software store request |
| recall_done_i | input | 1 | Recall finished; clears the dirty flag |
| mem_rd_req_i | input | 1 | Read strobe from the host |
| mem_wr_req_i | input | 1 | Write strobe from the host |
| mem_rd_en_o | output | 1 | Gated read strobe to the SRAM |
| mem_wr_en_o | output | 1 | Gated write strobe to the SRAM |
| eng_start_o | output | 1 | One-cycle start to the store engine |
| eng_done_i | input | 1 | Store engine finished |

## Verification
The bench targets the following corner cases:

- **Request with nothing to save.** A design that ignored the dirty flag would start a store that nothing calls for, and the scoreboard would see an unexpected start.
- **Write in the same cycle as the line falls.** A design that gated writes on the raw line rather than the synchronised one would drop a write that is already in flight.
- **Write in the same cycle as a recall finishes.** Clearing the flag with priority over the write would lose a pending store.
- **Gap between the end of a store and the line being seen high.** This is checked both with the host still holding the line and after a software store whose only low level was the controller's own. A design that reopened on done, or on a stale synchroniser value, would pass reads too early.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   typedef enum logic [2:0] {
      NVS_IDLE      = 3'd0,
      NVS_GRACE     = 3'd1,
      NVS_STORE     = 3'd2,
      NVS_WAIT_OPEN = 3'd3,
      NVS_WAIT_SHUT = 3'd4
   } nvs_state_e;

endpackage

// File: rtl/nvs_line_sync.sv
module nvs_line_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("nvs_line_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[i] <= RESET_VAL;
               else         chain_q[i] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[i] <= RESET_VAL;
               else         chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/nvs_grace_timer.sv
module nvs_grace_timer #(
   parameter int DELAY_CYC = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic expired_o
);

   generate
      if (DELAY_CYC < 1) begin : g_bad_delay
         $error("nvs_grace_timer: DELAY_CYC must be at least 1");
      end
      if (DELAY_CYC == 1) begin : g_single
         assign expired_o = run_i;
      end else begin : g_count
         localparam int CW = $clog2(DELAY_CYC);
         localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                    cnt_q <= '0;
            else if (!run_i || expired_o)   cnt_q <= '0;
            else                            cnt_q <= cnt_q + 1'b1;
         end

         assign expired_o = run_i && (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/nvs_dirty_flag.sv
module nvs_dirty_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic dirty_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dirty_o <= 1'b0;
      else if (set_i)  dirty_o <= 1'b1;
      else if (clr_i)  dirty_o <= 1'b0;
   end

endmodule

// File: rtl/nvs_store_handshake.sv
module nvs_store_handshake
   import nvs_pkg::*;
#(
   parameter int DELAY_CYC   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_line_i,
   output logic req_line_oe_o,
   input  logic sw_store_i,
   input  logic recall_done_i,
   input  logic mem_rd_req_i,
   input  logic mem_wr_req_i,
   output logic mem_rd_en_o,
   output logic mem_wr_en_o,
   output logic eng_start_o,
   input  logic eng_done_i
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("nvs_store_handshake: SYNC_STAGES must be at least 2");
      end
      if (DELAY_CYC < 1) begin : g_bad_delay
         $error("nvs_store_handshake: DELAY_CYC must be at least 1");
      end
   endgenerate

   nvs_state_e st_q, st_d;
   logic       line_hi;
   logic       grace_done;
   logic       dirty;
   logic       start_d, start_q;
   logic       wr_allow, rd_allow;
   logic       store_end;

   nvs_line_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b1)
   ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (req_line_i),
      .q_o   (line_hi)
   );

   nvs_grace_timer #(
      .DELAY_CYC(DELAY_CYC)
   ) u_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (st_q == NVS_GRACE),
      .expired_o(grace_done)
   );

   assign store_end = (st_q == NVS_STORE) && eng_done_i;

   nvs_dirty_flag u_dirty (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (mem_wr_en_o),
      .clr_i  (store_end || recall_done_i),
      .dirty_o(dirty)
   );

   always_comb begin
      st_d    = st_q;
      start_d = 1'b0;
      unique case (st_q)
         NVS_IDLE: begin
            if (!line_hi) begin
               st_d = NVS_GRACE;
            end else if (sw_store_i) begin
               st_d    = NVS_STORE;
               start_d = 1'b1;
            end
         end
         NVS_GRACE: begin
            if (grace_done) begin
               if (dirty) begin
                  st_d    = NVS_STORE;
                  start_d = 1'b1;
               end else begin
                  st_d = NVS_WAIT_OPEN;
               end
            end
         end
         NVS_STORE: begin
            if (eng_done_i) st_d = NVS_WAIT_SHUT;
         end
         NVS_WAIT_OPEN,
         NVS_WAIT_SHUT: begin
            if (line_hi) st_d = NVS_IDLE;
         end
         default: st_d = NVS_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q    <= NVS_IDLE;
         start_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         start_q <= start_d;
      end
   end

   assign wr_allow = (st_q == NVS_IDLE) && line_hi;
   assign rd_allow = (st_q == NVS_IDLE) || (st_q == NVS_GRACE) ||
                     (st_q == NVS_WAIT_OPEN);

   assign mem_wr_en_o   = mem_wr_req_i && wr_allow;
   assign mem_rd_en_o   = mem_rd_req_i && rd_allow;
   assign req_line_oe_o = (st_q == NVS_STORE);
   assign eng_start_o   = start_q;

endmodule

// File: rtl/nvs_store_handshake_chk.sv
module nvs_store_handshake_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic req_line_oe_o,
   input logic mem_rd_en_o,
   input logic mem_wr_en_o,
   input logic eng_start_o,
   input logic eng_done_i
);

   // R7
   store_blocks_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_line_oe_o |-> !mem_wr_en_o);

   // R7
   store_blocks_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_line_oe_o |-> !mem_rd_en_o);

   // R7
   start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eng_start_o |=> !eng_start_o);

   // R7
   start_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eng_start_o |-> req_line_oe_o);

   // R8
   busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_line_oe_o && !eng_done_i) |=> req_line_oe_o);

   // R8
   busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_line_oe_o && eng_done_i) |=> !req_line_oe_o);

   // R9
   shut_after_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(req_line_oe_o) |-> (!mem_rd_en_o && !mem_wr_en_o));

endmodule

bind nvs_store_handshake nvs_store_handshake_chk u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .req_line_oe_o(req_line_oe_o),
   .mem_rd_en_o  (mem_rd_en_o),
   .mem_wr_en_o  (mem_wr_en_o),
   .eng_start_o  (eng_start_o),
   .eng_done_i   (eng_done_i)
);

// File: tb/nvs_store_handshake_tb.sv
module nvs_store_handshake_tb;

   localparam int CLK_PERIOD = 10;
   localparam int DELAY      = 4;
   localparam int STORE_LEN  = 5;
   localparam int LAT        = 3 + DELAY;

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic host_low = 1'b0;
   logic sw_store = 1'b0, recall_done = 1'b0;
   logic rd_req = 1'b0, wr_req = 1'b0;
   logic line_raw, line_oe, rd_en, wr_en, eng_start, eng_done;
   int   scnt;
   int   cyc = 0;
   int   checks = 0, errors = 0;
   int   exp_q[$];
   int   s_cyc, n, m;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign line_raw = (host_low || line_oe) ? 1'b0 : 1'b1;

   // store engine stub
   always @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)          scnt <= 0;
      else if (eng_start)   scnt <= STORE_LEN;
      else if (scnt != 0)   scnt <= scnt - 1;
   end
   assign eng_done = (scnt == 1);

   nvs_store_handshake #(.DELAY_CYC(DELAY), .SYNC_STAGES(2)) u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_ni),
      .req_line_i   (line_raw),
      .req_line_oe_o(line_oe),
      .sw_store_i   (sw_store),
      .recall_done_i(recall_done),
      .mem_rd_req_i (rd_req),
      .mem_wr_req_i (wr_req),
      .mem_rd_en_o  (rd_en),
      .mem_wr_en_o  (wr_en),
      .eng_start_o  (eng_start),
      .eng_done_i   (eng_done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic tick(input int k = 1);
      for (int i = 0; i < k; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic probe();
      @(negedge clk);
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) tick();
   endtask

   task automatic expect_start(input int c);
      exp_q.push_back(c);
      s_cyc = c;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // scoreboard monitor: every start pulse must match a queued expectation (R2 R3 R4 R10)
   always @(negedge clk) begin
      if (rst_ni && eng_start) begin
         if (exp_q.size() == 0) begin
            chk("R3 unexpected start", cyc, -1);
         end else begin
            chk("R2 start cycle", cyc, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      summary();
      $finish;
   end

   initial begin
      // R1 reset state
      tick(3);
      probe();
      chk("R1 oe in reset", line_oe, 0);
      chk("R1 start in reset", eng_start, 0);
      tick();
      rst_ni = 1'b1;
      tick();
      rd_req = 1'b1;
      probe();
      chk("R1 read passes", rd_en, 1);
      tick();
      rd_req = 1'b0;
      wr_req = 1'b1;
      probe();
      chk("R1 write passes", wr_en, 1);
      tick();
      wr_req = 1'b0;
      recall_done = 1'b1;
      tick();
      recall_done = 1'b0;

      // clean request: no store (R3), reads ok (R6), writes blocked (R5)
      tick();
      host_low = 1'b1;
      tick(LAT + 2);
      rd_req = 1'b1;
      wr_req = 1'b1;
      probe();
      chk("R3 no busy on clean", line_oe, 0);
      chk("R6 read after skip", rd_en, 1);
      chk("R5 write blocked", wr_en, 0);
      tick();
      rd_req = 1'b0;
      wr_req = 1'b0;
      host_low = 1'b0;
      n = cyc;
      tick(2);
      wr_req = 1'b1;
      probe();
      chk("R5 write blocked before idle", wr_en, 0);
      tick();
      probe();
      chk("R5 write reopens", wr_en, 1);
      tick();
      wr_req = 1'b0;

      // dirty request with in-flight write (R2 R5 R6 R7 R8 R9)
      tick();
      host_low = 1'b1;
      wr_req = 1'b1;
      n = cyc;
      expect_start(n + LAT);
      probe();
      chk("R5 in-flight write", wr_en, 1);
      tick();
      wr_req = 1'b0;
      wait_until(n + 4);
      rd_req = 1'b1;
      wr_req = 1'b1;
      probe();
      chk("R6 read in grace", rd_en, 1);
      chk("R5 write in grace", wr_en, 0);
      tick();
      wr_req = 1'b0;
      wait_until(s_cyc + 2);
      probe();
      chk("R7 busy during store", line_oe, 1);
      chk("R7 read blocked in store", rd_en, 0);
      wait_until(s_cyc + STORE_LEN);
      probe();
      chk("R8 busy held until done", line_oe, 1);
      wait_until(s_cyc + STORE_LEN + 1);
      probe();
      chk("R8 busy released", line_oe, 0);
      chk("R9 read blocked line low", rd_en, 0);
      tick();
      host_low = 1'b0;
      m = cyc;
      tick(2);
      probe();
      chk("R9 still blocked", rd_en, 0);
      tick();
      probe();
      chk("R9 reopen", rd_en, 1);
      tick();
      rd_req = 1'b0;

      // dirty cleared by the store: new request runs no store (R4)
      host_low = 1'b1;
      tick(LAT + 2);
      probe();
      chk("R4 cleared after store", line_oe, 0);
      tick();
      host_low = 1'b0;
      tick(4);

      // write and recall in the same cycle keep the flag set (R4)
      wr_req = 1'b1;
      recall_done = 1'b1;
      tick();
      wr_req = 1'b0;
      recall_done = 1'b0;
      tick();
      host_low = 1'b1;
      n = cyc;
      expect_start(n + LAT);
      wait_until(s_cyc + 1);
      probe();
      chk("R4 write wins over recall", line_oe, 1);
      wait_until(s_cyc + STORE_LEN + 2);
      host_low = 1'b0;
      tick(4);

      // recall after a write clears the flag (R4)
      wr_req = 1'b1;
      tick();
      wr_req = 1'b0;
      recall_done = 1'b1;
      tick();
      recall_done = 1'b0;
      host_low = 1'b1;
      tick(LAT + 2);
      probe();
      chk("R4 recall clears", line_oe, 0);
      tick();
      host_low = 1'b0;
      tick(4);

      // software store from clean state (R10 R9)
      sw_store = 1'b1;
      n = cyc;
      expect_start(n + 1);
      tick();
      sw_store = 1'b0;
      wait_until(s_cyc + 2);
      probe();
      chk("R10 sw store busy", line_oe, 1);
      wait_until(s_cyc + STORE_LEN + 1);
      rd_req = 1'b1;
      probe();
      chk("R10 sw busy released", line_oe, 0);
      chk("R9 blocked after sw store", rd_en, 0);
      wait_until(s_cyc + STORE_LEN + 4);
      probe();
      chk("R10 reopen after own release", rd_en, 1);
      tick();
      rd_req = 1'b0;
      tick(3);

      chk("R2 all expected starts seen", exp_q.size(), 0);
      summary();
      $finish;
   end

endmodule